// File: doc/BRIEF.md
# Gated Pulse Width Counter

This block measures how long an external gate input stays high. While the counter is enabled, it counts the falling edges of the gate ANDed with a selectable internal count clock. A window that lasts several count-clock periods therefore leaves a count of periods in the counter. The count is not cleared when a window ends. The next gate-high period adds to the stored value, until software applies the clear strobe, usually from its interrupt handler after reading the result.

The gate is asynchronous. It passes through a synchroniser before it is combined with the count clock. The count clock is a level that arrives synchronous to the system clock from a prescaler outside this block. An interrupt request pulse marks the end of a window, and optionally its start as well. A wrap of the counter from all ones to zero sets a sticky overflow flag. The gate is sampled at the count clock's falling edge. A gate that drops while the count clock is high therefore adds one extra count.

Top module: `gate_width_counter`

## Requirements
- R1: After reset, the count is 0, the overflow flag is 0 and no interrupt pulse is given.
- R2: While enabled (`run_ctl`=1), the count increases by one for each falling edge of the synchronised gate ANDed with `cnt_clk_in`. No other event changes the count, except a clear or a wrap to 0.
- R3: The count width is `CNT_W` bits (default 18). Incrementing from all ones (0x3FFFF at the default width) gives 0 and sets `ovf_o` to 1.
- R4: `ovf_o` is sticky. It stays 1 across further counting and window ends until `clr_strobe` is applied.
- R5: A one-cycle `clr_strobe` sets the count and `ovf_o` to 0 on the next clock edge. It wins over an increment in the same cycle.
- R6: The count is kept at the end of a window. Without a clear, the next window continues from the stored value.
- R7: If the gate falls while `cnt_clk_in` is high, the window ends with one count more than the number of complete count-clock pulses inside it.
- R8: While enabled, with `both_edge_sel`=0, one `irq_o` pulse is given on each gate falling edge. With `both_edge_sel`=1, one pulse is given on each gate rising edge and one on each falling edge.
- R9: While disabled, gate activity changes neither the count nor `irq_o`.
- R10: Changing `run_ctl` from 1 to 0 while the synchronised gate is high gives one `irq_o` pulse.
- R11: Changing `run_ctl` from 0 to 1 while the synchronised gate is high gives one `irq_o` pulse when `both_edge_sel`=1, and none when it is 0.
- R12: `irq_o` is high for exactly one clock cycle for each event that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_in | input | 1 | Asynchronous window (gate) input |
| cnt_clk_in | input | 1 | Selected internal count clock, a level synchronous to clk |
| run_ctl | input | 1 | 1 = counting enabled, 0 = stopped |
| clr_strobe | input | 1 | One-cycle strobe that clears the count and the overflow flag |
| both_edge_sel | input | 1 | Interrupt edge select: 0 = gate falling edge only, 1 = both edges |
| count_o | output | CNT_W | Accumulated count |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request, one-cycle pulse |

## Verification
The assertions assume that `cnt_clk_in` and the control inputs are stable, synchronous levels, and that `clr_strobe` is a strobe of a single cycle. The stimulus drives every input on the falling system-clock edge. It holds each count-clock level for two cycles and waits past the synchroniser latency before it changes the run control relative to the gate. It keeps the count clock low at every start and stop, so that no count edge falls in the cycle where the enable changes. Interrupt counts and stored values are compared only after the block has gone quiet.

// File: rtl/gwc_pkg.sv
package gwc_pkg;
    // One-cycle event flags produced by the edge detector.
    typedef struct packed {
        logic gate_rise;
        logic gate_fall;
        logic cnt_edge;
        logic run_start;
        logic run_stop;
    } gwc_evt_t;
endpackage

// File: rtl/gwc_sync.sv
module gwc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gwc_events.sv
module gwc_events
    import gwc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     gate_s,
    input  logic     cnt_clk,
    input  logic     run,
    output gwc_evt_t evt_o,
    output logic     running_o
);
    typedef struct packed {
        logic gate_prev;
        logic and_q;
        logic and_qq;
        logic run_q;
    } ev_state_t;

    ev_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.gate_prev = gate_s;
        st_d.and_q     = gate_s & cnt_clk;
        st_d.and_qq    = st_q.and_q;
        st_d.run_q     = run;

        evt_o.gate_rise = gate_s & ~st_q.gate_prev;
        evt_o.gate_fall = ~gate_s & st_q.gate_prev;
        evt_o.cnt_edge  = st_q.and_qq & ~st_q.and_q & st_q.run_q;
        evt_o.run_start = run & ~st_q.run_q;
        evt_o.run_stop  = ~run & st_q.run_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running_o = st_q.run_q;
endmodule

// File: rtl/gwc_counter.sv
module gwc_counter #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_MAX) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign ovf_o   = st_q.ovf;
endmodule

// File: rtl/gwc_irq.sv
module gwc_irq
    import gwc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  gwc_evt_t evt,
    input  logic     gate_s,
    input  logic     running,
    input  logic     both_sel,
    output logic     irq_o
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = 1'b0;
        if (running && evt.gate_fall)              irq_d = 1'b1;
        if (running && both_sel && evt.gate_rise)  irq_d = 1'b1;
        if (evt.run_stop && gate_s)                irq_d = 1'b1;
        if (evt.run_start && both_sel && gate_s)   irq_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/gate_width_counter.sv
module gate_width_counter
    import gwc_pkg::*;
#(
    parameter int CNT_W       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_in,
    input  logic             cnt_clk_in,
    input  logic             run_ctl,
    input  logic             clr_strobe,
    input  logic             both_edge_sel,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             irq_o
);
    logic     gate_s;
    logic     running;
    gwc_evt_t evt;

    gwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gate_in),
        .q     (gate_s)
    );

    gwc_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_s    (gate_s),
        .cnt_clk   (cnt_clk_in),
        .run       (run_ctl),
        .evt_o     (evt),
        .running_o (running)
    );

    gwc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_strobe),
        .inc     (evt.cnt_edge),
        .count_o (count_o),
        .ovf_o   (ovf_o)
    );

    gwc_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .gate_s   (gate_s),
        .running  (running),
        .both_sel (both_edge_sel),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/gwc_checker.sv
module gwc_checker #(
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_ctl,
    input logic             clr_strobe,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o,
    input logic             irq_o
);
    // R2 R3: the count only steps by one, wraps to zero or is cleared
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |->
            (count_o == $past(count_o) + 1'b1) || (count_o == '0));

    // R3: overflow rises only together with a wrap to zero
    assert_ovf_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (count_o == '0) && ($past(count_o) == {CNT_W{1'b1}}));

    // R4: overflow stays set until a clear
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_strobe) |=> ovf_o);

    // R5: clear empties count and overflow on the next edge
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strobe |=> (count_o == '0) && !ovf_o);

    // R9: stopped for two cycles means no interrupt
    assert_quiet_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run_ctl) && !$past(run_ctl, 2)) |-> !irq_o);

    // R9: stopped means the count holds unless cleared
    assert_quiet_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run_ctl, 2) && !$past(clr_strobe)) |-> $stable(count_o));
endmodule

bind gate_width_counter gwc_checker #(.CNT_W(CNT_W)) u_gwc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_ctl    (run_ctl),
    .clr_strobe (clr_strobe),
    .count_o    (count_o),
    .ovf_o      (ovf_o),
    .irq_o      (irq_o)
);

// File: tb/test_gate_width_counter.sv
module test_gate_width_counter;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;

    typedef struct {
        int    cnt;
        int    ovf;
        int    irqs;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gate_in = 1'b0;
    logic             cnt_clk_in = 1'b0;
    logic             run_ctl = 1'b0;
    logic             clr_strobe = 1'b0;
    logic             both_edge_sel = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic             ovf_o;
    logic             irq_o;

    int   total = 0;
    int   bad = 0;
    int   irq_seen = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_width_counter #(.CNT_W(CNT_W)) i_gate_width_counter (
        .clk           (clk),
        .rst_n         (rst_n),
        .gate_in       (gate_in),
        .cnt_clk_in    (cnt_clk_in),
        .run_ctl       (run_ctl),
        .clr_strobe    (clr_strobe),
        .both_edge_sel (both_edge_sel),
        .count_o       (count_o),
        .ovf_o         (ovf_o),
        .irq_o         (irq_o)
    );

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: counts irq pulses and pops expected items
    initial begin
        forever begin
            @(negedge clk);
            if (irq_o) irq_seen++;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "count", int'(count_o), e.cnt);
                check(e.tag, "ovf", int'(ovf_o), e.ovf);
                check(e.tag, "irqs", irq_seen, e.irqs);
                irq_seen = 0;
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(int c, int o, int i, string tag);
        exp_t e;
        idle(8);
        e.cnt = c; e.ovf = o; e.irqs = i; e.tag = tag;
        sb.push_back(e);
        wait (sb.size() == 0);
        idle(1);
    endtask

    task automatic pulses(int n);
        for (int k = 0; k < n; k++) begin
            cnt_clk_in = 1'b1; idle(2);
            cnt_clk_in = 1'b0; idle(2);
        end
    endtask

    task automatic clear();
        clr_strobe = 1'b1; idle(1);
        clr_strobe = 1'b0; idle(1);
    endtask

    // one gate window with n count pulses, optionally ending with the clock high
    task automatic window(int n, bit end_high);
        gate_in = 1'b1; idle(4);
        pulses(n);
        if (end_high) begin
            cnt_clk_in = 1'b1; idle(2);
            gate_in = 1'b0; idle(6);
            cnt_clk_in = 1'b0; idle(2);
        end else begin
            gate_in = 1'b0; idle(4);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        expect_now(0, 0, 0, "R1 reset state");

        run_ctl = 1'b1; idle(3);
        window(5, 1'b0);
        expect_now(5, 0, 1, "R2 R8 window falling-edge irq");

        window(3, 1'b0);
        expect_now(8, 0, 1, "R6 accumulate across windows");

        clear();
        expect_now(0, 0, 0, "R5 clear");

        window(4, 1'b1);
        expect_now(5, 0, 1, "R7 gate falls with clock high");

        clear();
        both_edge_sel = 1'b1;
        window(3, 1'b0);
        expect_now(3, 0, 2, "R8 R12 both-edge irq");

        run_ctl = 1'b0; idle(3);
        window(4, 1'b1);
        expect_now(3, 0, 0, "R9 stopped ignores gate");

        both_edge_sel = 1'b0;
        clear();
        run_ctl = 1'b1; idle(3);
        gate_in = 1'b1; idle(4);
        pulses(2);
        run_ctl = 1'b0; idle(4);
        gate_in = 1'b0; idle(4);
        expect_now(2, 0, 1, "R10 stop with gate high");

        clear();
        both_edge_sel = 1'b1;
        gate_in = 1'b1; idle(5);
        run_ctl = 1'b1; idle(3);
        pulses(3);
        gate_in = 1'b0; idle(4);
        expect_now(3, 0, 2, "R11 start with gate high both edges");

        run_ctl = 1'b0; idle(3);
        clear();
        both_edge_sel = 1'b0;
        gate_in = 1'b1; idle(5);
        run_ctl = 1'b1; idle(3);
        pulses(3);
        gate_in = 1'b0; idle(4);
        expect_now(3, 0, 1, "R11 start with gate high falling only");

        clear();
        window((1 << CNT_W) - 1, 1'b0);
        expect_now((1 << CNT_W) - 1, 0, 1, "R3 all ones no overflow");

        window(1, 1'b0);
        expect_now(0, 1, 1, "R3 wrap sets overflow");

        window(2, 1'b0);
        expect_now(2, 1, 1, "R4 overflow sticky");

        clear();
        expect_now(0, 0, 0, "R4 R5 clear drops overflow");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule